// File: doc/BRIEF.md
# Multi-Channel SPI Register Access Engine

This block is a small SPI master that lets on-chip logic read and write single-byte registers inside a multi-channel telephony line-interface device. All channels share one chip-select, one clock and one data line pair. The channel is chosen by a field carried in the first byte of every access.

A host presents one request at a time. Each request carries a write/read flag, a channel number, a register address and a write byte. The engine checks that the request can be served. It then sends a command byte and an address byte, and after those either sends the write byte or clocks in the read byte. Each byte sits in its own chip-select frame. The bus runs in SPI mode 3, with the clock idling high. A finished access raises a one-cycle completion pulse, and a read also places the returned byte on the read-data output. A request that cannot be served raises a one-cycle error pulse instead and leaves the bus untouched.

A channel value of all ones addresses every channel at once. This broadcast form is only allowed for writes.

Top module: `spi_reg_engine`

## Requirements
- R1: The command byte has the reversed channel field in bits [4:0]. A read sets bits 6 and 5 (0x60); a write sets bit 5 only (0x20).
- R2: A channel value of 0xFF with the write flag set is a broadcast write, whose command byte is 0xA0.
- R3: The channel field is the 5-bit channel number with its bit order reversed: bit 0 of the channel goes to bit 4 of the command byte, and so on. For example, channel 1 gives 0x10, channel 2 gives 0x08 and channel 7 gives 0x1C.
- R4: A write puts three bytes on MOSI in this order: the command byte, the register address, the write data. A read sends the command byte and the address, then shifts in a third byte from MISO. That byte appears on `rd_data` in the same cycle as `done`.
- R5: SCLK is high whenever CSn is high. Within a frame, MOSI changes only when SCLK falls, and MISO is sampled when SCLK rises. Bits go most significant first.
- R6: Every byte forms its own CSn-low frame of exactly 8 SCLK rising edges. Between frames, CSn stays high for at least one SCLK period.
- R7: A request with a channel at or above `MAX_CHAN` that is not 0xFF gives a one-cycle `err` pulse, no `done`, and no CSn or SCLK activity.
- R8: A channel value of 0xFF with the read flag set is rejected in the same way as R7.
- R9: One SCLK period lasts `CLK_DIV` system clock cycles, where `CLK_DIV` is even.
- R10: While reset is held, and just after it, CSn, SCLK and MOSI are high, `req_ready` is high, and `done` and `err` are low.
- R11: `done` and `err` are one-cycle pulses that never occur together. `req_ready` is low from the cycle after an accepted request until the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present; it is taken when `req_ready` is high |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_chan | input | 8 | Channel number; 0xFF selects broadcast |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle pulse when an access completes |
| err | output | 1 | One-cycle pulse when a request is rejected |
| rd_data | output | 8 | Byte returned by the last read |
| sclk | output | 1 | SPI clock, idles high |
| csn | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Master-out data |
| miso | input | 1 | Master-in data |

## Verification
The assertions assume that MISO settles before the SCLK rising edge and that `req_valid` is only meaningful while `req_ready` is high. The stimulus respects both. The bench's slave model changes MISO only on SCLK falling edges, and the driver raises a request for exactly one cycle after it sees the engine idle. The driver also waits until the previous result has been scored before it issues the next request, so every pulse can be matched to a single expected item.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int CH_BITS = 5;
  localparam logic [7:0] CMD_READ  = 8'h60;
  localparam logic [7:0] CMD_WRITE = 8'h20;
  localparam logic [7:0] CMD_ALL   = 8'h80;
  localparam logic [7:0] CHAN_ALL  = 8'hFF;
  localparam int BYTES_PER_ACCESS  = 3;
  localparam int LAST_BIT_HALF     = 15;
  localparam int CS_RISE_HALF      = 16;
  localparam int LAST_HALF         = 18;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_BUSY = 1'b1} eng_state_t;
endpackage

// File: rtl/spi_cmd_encode.sv
module spi_cmd_encode
  import spi_reg_pkg::*;
#(
  parameter int MAX_CHAN = 8
) (
  input  logic [7:0] chan,
  input  logic       write,
  output logic [7:0] cmd,
  output logic       reject
);
  logic [CH_BITS-1:0] rev;
  logic               is_all;

  for (genvar i = 0; i < CH_BITS; i++) begin : g_rev
    assign rev[i] = chan[CH_BITS-1-i];
  end

  assign is_all = (chan == CHAN_ALL);

  always_comb begin
    if (is_all) begin
      cmd    = CMD_ALL | CMD_WRITE;
      reject = !write;
    end else begin
      cmd    = (write ? CMD_WRITE : CMD_READ) | {{(8-CH_BITS){1'b0}}, rev};
      reject = ({24'd0, chan} >= 32'(MAX_CHAN));
    end
  end
endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || cnt == CNT_LAST) cnt <= '0;
    else                                cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == CNT_LAST);

  if (HALF > 1) begin : g_spacing
    p_tick_spacing_r9: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
  end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       fall,
  input  logic       rise,
  input  logic       miso,
  output logic       mosi,
  output logic [7:0] rx
);
  logic [7:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      mosi <= 1'b1;
      rx   <= '0;
    end else begin
      if (load) begin
        sh   <= load_byte;
        mosi <= load_byte[7];
      end else if (fall) begin
        mosi <= sh[7];
        sh   <= {sh[6:0], 1'b0};
      end
      if (rise) rx <= {rx[6:0], miso};
    end
  end
endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
  import spi_reg_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int MAX_CHAN = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [7:0] req_chan,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       done,
  output logic       err,
  output logic [7:0] rd_data,
  output logic       sclk,
  output logic       csn,
  output logic       mosi,
  input  logic       miso
);
  localparam int HALF = CLK_DIV / 2;

  eng_state_t  state;
  logic [4:0]  h;
  logic [1:0]  bidx;
  logic        is_rd;
  logic [7:0]  addr_q, wdata_q;
  logic [7:0]  cmd;
  logic        reject;
  logic        tick, fall, rise, load, accept, start, byte_end, last_byte;
  logic [7:0]  load_byte, rx;

  spi_cmd_encode #(.MAX_CHAN(MAX_CHAN)) u_enc (
    .chan(req_chan), .write(req_write), .cmd(cmd), .reject(reject));

  spi_half_tick #(.HALF(HALF)) u_tick (
    .clk(clk), .rst(rst), .run(state == ST_BUSY), .tick(tick));

  assign accept    = (state == ST_IDLE) && req_valid;
  assign start     = accept && !reject;
  assign byte_end  = tick && (h == 5'(LAST_HALF));
  assign last_byte = (bidx == 2'(BYTES_PER_ACCESS - 1));
  assign fall      = tick && (h <= 5'(LAST_BIT_HALF)) && !h[0];
  assign rise      = tick && (h <= 5'(LAST_BIT_HALF)) &&  h[0];
  assign load      = start || (byte_end && !last_byte);
  assign load_byte = start ? cmd : ((bidx == 2'd0) ? addr_q : wdata_q);
  assign req_ready = (state == ST_IDLE);

  spi_byte_shift u_shift (
    .clk(clk), .rst(rst), .load(load), .load_byte(load_byte),
    .fall(fall), .rise(rise), .miso(miso), .mosi(mosi), .rx(rx));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      h       <= '0;
      bidx    <= '0;
      is_rd   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      csn     <= 1'b1;
      sclk    <= 1'b1;
      done    <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (state == ST_IDLE) begin
        if (accept && reject) err <= 1'b1;
        if (start) begin
          state   <= ST_BUSY;
          h       <= '0;
          bidx    <= '0;
          is_rd   <= !req_write;
          addr_q  <= req_addr;
          wdata_q <= req_write ? req_wdata : 8'h00;
          csn     <= 1'b0;
        end
      end else if (tick) begin
        if (fall) sclk <= 1'b0;
        if (rise) sclk <= 1'b1;
        if (h == 5'(CS_RISE_HALF)) csn <= 1'b1;
        if (byte_end) begin
          h <= '0;
          if (last_byte) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            if (is_rd) rd_data <= rx;
          end else begin
            bidx <= bidx + 1'b1;
            csn  <= 1'b0;
          end
        end else begin
          h <= h + 1'b1;
        end
      end
    end
  end

  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
    csn |-> sclk);
  p_mosi_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (!csn && !$past(csn) && sclk && $past(sclk)) |-> $stable(mosi));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_err_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  p_err_no_bus_r7: assert property (@(posedge clk) disable iff (rst)
    err |-> (csn && sclk));
  p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (rst)
    !csn |-> !req_ready);
endmodule

// File: tb/test_spi_reg_engine.sv
`timescale 1ns/1ps
module test_spi_reg_engine;
  localparam int CLK_DIV  = 4;
  localparam int MAX_CHAN = 8;
  localparam int TCLK     = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_chan = '0, req_addr = '0, req_wdata = '0;
  logic req_ready, done, err, sclk, csn, mosi;
  logic miso = 1'b0;
  logic [7:0] rd_data;

  spi_reg_engine #(.CLK_DIV(CLK_DIV), .MAX_CHAN(MAX_CHAN)) i_spi_reg_engine (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_chan(req_chan), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .err(err), .rd_data(rd_data),
    .sclk(sclk), .csn(csn), .mosi(mosi), .miso(miso));

  typedef struct {
    logic [7:0] c, a, d;
    logic       rd, er;
  } item_t;

  item_t      sb_q[$];
  logic [7:0] cap_q[$];
  int nchk = 0, nfail = 0;
  bit armed = 0;

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cmd(bit w, logic [7:0] ch);
    logic [7:0] r;
    if (ch == 8'hFF) return 8'hA0;
    r = 8'h00;
    for (int i = 0; i < 5; i++) r[4-i] = ch[i];
    return r | (w ? 8'h20 : 8'h60);
  endfunction

  // slave capture: R5, R6, R9
  logic [7:0] csh;
  int bits, falls;
  time t_fall, t_csup;
  always @(negedge csn) if (armed) begin
    bits = 0; falls = 0;
    if (t_csup > 0) check("R6 gap", 32'((($time - t_csup) >= CLK_DIV*TCLK)), 1);
  end
  always @(posedge sclk) if (armed && !csn) begin
    csh = {csh[6:0], mosi};
    bits++;
  end
  always @(posedge csn) if (armed) begin
    check("R6 bits per frame", 32'(bits), 8);
    cap_q.push_back(csh);
    t_csup = $time;
  end
  always @(negedge sclk) if (armed && !csn) begin
    if (falls >= 1) check("R9 sclk period", 32'($time - t_fall), CLK_DIV*TCLK);
    t_fall = $time;
    if ((cap_q.size() % 3) == 2 && cap_q[cap_q.size()-2][6]) begin
      logic [7:0] resp;
      resp = cap_q[cap_q.size()-2] ^ cap_q[cap_q.size()-1];
      miso = resp[7-falls];
    end
    falls++;
  end

  // monitor / scoreboard
  always @(negedge clk) if (armed && (done || err)) begin
    if (sb_q.size() == 0) begin
      check("R11 unexpected result", 32'({done, err}), 0);
    end else begin
      item_t it;
      it = sb_q.pop_front();
      if (it.er) begin
        check("R7/R8 err pulse", 32'(err), 1);
        check("R7/R8 no bus frames", 32'(cap_q.size()), 0);
      end else begin
        check("R11 done not err", 32'({done, err}), 32'b10);
        check("R6 frame count", 32'(cap_q.size()), 3);
        if (cap_q.size() == 3) begin
          check("R1 R2 R3 command byte", 32'(cap_q[0]), 32'(it.c));
          check("R4 address byte", 32'(cap_q[1]), 32'(it.a));
          if (it.rd) check("R4 read data", 32'(rd_data), 32'(it.c ^ it.a));
          else       check("R4 write data byte", 32'(cap_q[2]), 32'(it.d));
        end
      end
      cap_q.delete();
    end
  end

  task automatic req(bit w, logic [7:0] ch, logic [7:0] a, logic [7:0] d);
    item_t it;
    it.c = exp_cmd(w, ch); it.a = a; it.d = d; it.rd = !w;
    it.er = (ch == 8'hFF) ? !w : (ch >= MAX_CHAN);
    sb_q.push_back(it);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_chan = ch; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (!it.er) check("R11 ready low when busy", 32'(req_ready), 0);
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(200000 * TCLK);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R10 reset csn", 32'(csn), 1);
    check("R10 reset sclk", 32'(sclk), 1);
    check("R10 reset mosi", 32'(mosi), 1);
    check("R10 reset ready", 32'(req_ready), 1);
    check("R10 reset pulses", 32'({done, err}), 0);
    rst = 1'b0;
    armed = 1;
    @(negedge clk);
    check("R10 idle after reset", 32'({csn, sclk, req_ready}), 32'b111);
    req(1, 8'd0, 8'h12, 8'hA5);   // R1 R3 ch0
    req(1, 8'd1, 8'h34, 8'h5A);   // R3 ch1 -> 0x10
    req(1, 8'd2, 8'h00, 8'hFF);   // R3 ch2 -> 0x08
    req(1, 8'd7, 8'hFF, 8'h00);   // R3 ch7 -> 0x1C
    req(0, 8'd3, 8'h2C, 8'h00);   // R4 read
    req(0, 8'd5, 8'h81, 8'h00);   // R4 read
    req(0, 8'd0, 8'hFF, 8'h00);   // R4 read boundary address
    req(1, 8'hFF, 8'h40, 8'h3C);  // R2 broadcast write
    req(0, 8'hFF, 8'h40, 8'h00);  // R8 broadcast read rejected
    req(1, 8'd8, 8'h11, 8'h22);   // R7 first out-of-range channel
    req(0, 8'd200, 8'h11, 8'h00); // R7 far out of range
    req(0, 8'd6, 8'h77, 8'h00);   // R4 read after rejects
    repeat (10) @(negedge clk);
    check("R11 idle at end", 32'({csn, req_ready}), 32'b11);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule